// File: doc/BRIEF.md
# Host Port Video Memory Write Interface

This block connects an 8-bit host I/O port to the write side of a frame-buffer memory. The host writes to one of eight command ports on this board. The low nibble of the I/O address selects the board, and the next three address bits select the command. The host first claims the memory bus. It then loads a column and a row address from the data bus and writes a pixel byte at that location. When it has finished, it hands the bus back to the display reader.

The host write strobe is asynchronous to the block clock. A synchronizer brings it into the clock domain, and each rising edge of the synchronized strobe is taken as exactly one command. While the host owns the bus, a grant flag tells the display reader to float its own row and column address drivers. A separate run flag starts at zero after reset and is set by one command. This keeps the rest of the adapter idle until the host is ready for blanking notifications. The memory can only be written; nothing is read back through this block.

Top module: `vram_host_port`

## Requirements
- R1: After reset, `bus_grant_o`, `adapter_run_o` and `mem_we_o` are 0, and the three memory outputs read 0.
- R2: A command is acted on only when `io_addr_i[3:0]` equals `board_id_i`. A mismatched command changes no output and gives no write pulse.
- R3: Opcode 0 (`io_addr_i[6:4]`=0) sets `bus_grant_o`. Its data value has no effect on any latch.
- R4: While granted, opcode 1 loads the data byte into the column latch and opcode 2 loads it into the row latch.
- R5: Opcodes 1 and 2 issued while not granted leave both latches unchanged. The values are observed after a later grant.
- R6: While granted, opcode 3 loads the data byte onto `mem_data_o` and gives exactly one `mem_we_o` pulse, one clock long, with the latched column and row on the address outputs. When not granted, opcode 3 gives no pulse and changes nothing.
- R7: Opcode 4 clears `bus_grant_o`. While not granted, `mem_col_o`, `mem_row_o` and `mem_data_o` read 0. The latches keep their contents for the next grant.
- R8: Opcode 5 sets `adapter_run_o`. The flag does not depend on the grant, and only reset clears it.
- R9: Opcodes 6 and 7 change no state and give no pulse.
- R10: One strobe assertion carries out one command, however long the strobe is held.
- R11: After a single grant, any number of column, row and write commands may follow before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| board_id_i | input | 4 | Board address this port answers to |
| io_addr_i | input | 7 | Host I/O address: [3:0] board, [6:4] opcode |
| io_data_i | input | 8 | Host data bus |
| io_wr_i | input | 1 | Host I/O write strobe, active high, asynchronous |
| mem_col_o | output | 8 | Column address to memory (0 when not granted) |
| mem_row_o | output | 8 | Row address to memory (0 when not granted) |
| mem_data_o | output | 8 | Write data to memory (0 when not granted) |
| mem_we_o | output | 1 | Single-cycle memory write pulse |
| bus_grant_o | output | 1 | Host owns the memory bus; the display reader floats its drivers |
| adapter_run_o | output | 1 | Adapter released from reset |

## Verification
Random command streams mix all eight opcodes and matching and non-matching board nibbles. Because the grant state is random at each command, latch loads and writes arrive both inside and outside a grant, which shows whether the column, row and write gating follows ownership. Directed sequences cover several cases:
- Latch loads before any grant, which separates a latch that is dead until granted from one that is merely hidden by the output gating.
- A long-held strobe, which separates edge-triggered from level-triggered command execution.
- Several writes inside one grant, which shows that the latched addresses persist between writes.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

    localparam int VHP_DW = 8;

    typedef enum logic [2:0] {
        OP_GRANT   = 3'd0,
        OP_COL     = 3'd1,
        OP_ROW     = 3'd2,
        OP_WRITE   = 3'd3,
        OP_RELEASE = 3'd4,
        OP_RUN     = 3'd5,
        OP_NOP6    = 3'd6,
        OP_NOP7    = 3'd7
    } vhp_op_e;

    typedef struct packed {
        logic              grant;
        logic              run;
        logic              we;
        logic [VHP_DW-1:0] col;
        logic [VHP_DW-1:0] row;
        logic [VHP_DW-1:0] data;
    } vhp_state_t;

endpackage

// File: rtl/vhp_strobe_sync.sv
module vhp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= strobe_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vhp_decode.sv
module vhp_decode
    import vhp_pkg::*;
#(
    parameter int BOARD_W = 4,
    parameter int OP_W    = 3,
    localparam int AW     = BOARD_W + OP_W
) (
    input  logic               fire_i,
    input  logic [BOARD_W-1:0] board_id_i,
    input  logic [AW-1:0]      addr_i,
    output logic               cmd_valid_o,
    output vhp_op_e            cmd_op_o
);
    logic hit;

    always_comb begin
        hit         = (addr_i[BOARD_W-1:0] == board_id_i);
        cmd_valid_o = fire_i & hit;
        cmd_op_o    = vhp_op_e'(addr_i[AW-1:BOARD_W]);
    end
endmodule

// File: rtl/vram_host_port.sv
module vram_host_port
    import vhp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BOARD_W     = 4,
    parameter int OP_W        = 3,
    parameter int DW          = VHP_DW,
    localparam int AW         = BOARD_W + OP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BOARD_W-1:0] board_id_i,
    input  logic [AW-1:0]      io_addr_i,
    input  logic [DW-1:0]      io_data_i,
    input  logic               io_wr_i,
    output logic [DW-1:0]      mem_col_o,
    output logic [DW-1:0]      mem_row_o,
    output logic [DW-1:0]      mem_data_o,
    output logic               mem_we_o,
    output logic               bus_grant_o,
    output logic               adapter_run_o
);
    logic       fire;
    logic       cmd_valid;
    vhp_op_e    cmd_op;
    vhp_state_t s_d, s_q;

    vhp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (io_wr_i),
        .rise_o   (fire)
    );

    vhp_decode #(.BOARD_W(BOARD_W), .OP_W(OP_W)) u_dec (
        .fire_i      (fire),
        .board_id_i  (board_id_i),
        .addr_i      (io_addr_i),
        .cmd_valid_o (cmd_valid),
        .cmd_op_o    (cmd_op)
    );

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_GRANT:   s_d.grant = 1'b1;
                OP_COL:     if (s_q.grant) s_d.col = io_data_i;
                OP_ROW:     if (s_q.grant) s_d.row = io_data_i;
                OP_WRITE: begin
                    if (s_q.grant) begin
                        s_d.data = io_data_i;
                        s_d.we   = 1'b1;
                    end
                end
                OP_RELEASE: s_d.grant = 1'b0;
                OP_RUN:     s_d.run   = 1'b1;
                default:    s_d = s_q;
            endcase
            if (cmd_op == OP_NOP6 || cmd_op == OP_NOP7) s_d.we = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_grant_o   = s_q.grant;
    assign adapter_run_o = s_q.run;
    assign mem_we_o      = s_q.we;
    assign mem_col_o     = s_q.grant ? s_q.col  : '0;
    assign mem_row_o     = s_q.grant ? s_q.row  : '0;
    assign mem_data_o    = s_q.grant ? s_q.data : '0;
endmodule

// File: rtl/vhp_checker.sv
module vhp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] mem_col_o,
    input logic [DW-1:0] mem_row_o,
    input logic [DW-1:0] mem_data_o,
    input logic          mem_we_o,
    input logic          bus_grant_o,
    input logic          adapter_run_o
);
    // R1: outputs idle while reset is held
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_idle_r1: assert (!bus_grant_o && !adapter_run_o && !mem_we_o);
        end
    end

    p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    p_we_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> bus_grant_o);

    p_data_moves_on_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant_o && $past(bus_grant_o) && !$stable(mem_data_o)) |-> mem_we_o);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant_o |-> (mem_col_o == '0 && mem_row_o == '0 && mem_data_o == '0));

    p_run_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adapter_run_o |=> adapter_run_o);
endmodule

bind vram_host_port vhp_checker #(.DW(DW)) u_chk (.*);

// File: tb/tb_vram_host_port.sv
module tb_vram_host_port;
    localparam logic [3:0] BOARD = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] board_id;
    logic [6:0] io_addr;
    logic [7:0] io_data;
    logic       io_wr;
    logic [7:0] mem_col, mem_row, mem_data;
    logic       mem_we, bus_grant, adapter_run;

    always #4 clk = ~clk;

    vram_host_port dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .board_id_i    (board_id),
        .io_addr_i     (io_addr),
        .io_data_i     (io_data),
        .io_wr_i       (io_wr),
        .mem_col_o     (mem_col),
        .mem_row_o     (mem_row),
        .mem_data_o    (mem_data),
        .mem_we_o      (mem_we),
        .bus_grant_o   (bus_grant),
        .adapter_run_o (adapter_run)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic       m_grant, m_run;
    logic [7:0] m_col, m_row, m_data;

    int         we_seen;
    logic [7:0] we_col, we_row, we_data;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op, input logic [3:0] b);
        if (b != BOARD) return "R2";
        case (op)
            3'd0: return "R3";
            3'd1, 3'd2: return m_grant ? "R4" : "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic int exp_pulses(input logic [2:0] op, input logic [3:0] b);
        return (b == BOARD && op == 3'd3 && m_grant) ? 1 : 0;
    endfunction

    task automatic model_step(input logic [2:0] op, input logic [3:0] b, input logic [7:0] d);
        if (b == BOARD) begin
            case (op)
                3'd0: m_grant = 1'b1;
                3'd1: if (m_grant) m_col = d;
                3'd2: if (m_grant) m_row = d;
                3'd3: if (m_grant) m_data = d;
                3'd4: m_grant = 1'b0;
                3'd5: m_run = 1'b1;
                default: ;
            endcase
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, "grant", 32'(bus_grant), 32'(m_grant));
        check(req, "run",   32'(adapter_run), 32'(m_run));
        check(req, "col",   32'(mem_col),  32'(m_grant ? m_col  : 8'h00));
        check(req, "row",   32'(mem_row),  32'(m_grant ? m_row  : 8'h00));
        check(req, "data",  32'(mem_data), 32'(m_grant ? m_data : 8'h00));
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] b,
                         input logic [7:0] d, input int hold);
        string rq;
        int    ep;
        rq = req_of(op, b);
        ep = exp_pulses(op, b);
        @(negedge clk);
        io_addr = {op, b};
        io_data = d;
        io_wr   = 1'b1;
        we_seen = 0;
        for (int i = 0; i < hold + 5; i++) begin
            @(negedge clk);
            if (i == hold - 1) io_wr = 1'b0;
            if (mem_we) begin
                we_seen++;
                we_col  = mem_col;
                we_row  = mem_row;
                we_data = mem_data;
            end
        end
        model_step(op, b, d);
        check(rq, "we pulses", 32'(we_seen), 32'(ep));
        if (ep == 1) begin
            check("R6", "write col",  32'(we_col),  32'(m_col));
            check("R6", "write row",  32'(we_row),  32'(m_row));
            check("R6", "write data", 32'(we_data), 32'(d));
        end
        check_outputs(rq);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        rst_n = 1'b0; board_id = BOARD; io_addr = '0; io_data = '0; io_wr = 1'b0;
        m_grant = 0; m_run = 0; m_col = 0; m_row = 0; m_data = 0;
        repeat (3) @(negedge clk);
        check_outputs("R1");
        check("R1", "we", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");

        // R5: latch loads before any grant are dropped
        issue(3'd1, BOARD, 8'h55, 4);
        issue(3'd2, BOARD, 8'h66, 4);
        issue(3'd3, BOARD, 8'h77, 4);
        // R2: wrong board grant ignored
        issue(3'd0, BOARD ^ 4'h1, 8'h00, 4);
        // R3: grant with data ignored, latches still reset values
        issue(3'd0, BOARD, 8'hFF, 4);
        // R11: several writes in one grant
        issue(3'd1, BOARD, 8'h12, 4);
        issue(3'd2, BOARD, 8'h34, 4);
        issue(3'd3, BOARD, 8'hA5, 4);
        issue(3'd2, BOARD, 8'h35, 4);
        issue(3'd3, BOARD, 8'h5A, 4);
        check("R11", "grant held", 32'(bus_grant), 32'd1);
        // R10: long strobe gives one pulse
        issue(3'd3, BOARD, 8'hC3, 12);
        // R9: no-op codes
        issue(3'd6, BOARD, 8'h99, 4);
        issue(3'd7, BOARD, 8'h98, 4);
        // R7: release, latches kept
        issue(3'd4, BOARD, 8'hEE, 4);
        issue(3'd3, BOARD, 8'h11, 4);
        issue(3'd0, BOARD, 8'h00, 4);
        check("R7", "col kept", 32'(mem_col), 32'h12);
        // R8: run flag
        issue(3'd5, BOARD, 8'h00, 4);
        issue(3'd4, BOARD, 8'h00, 4);
        check("R8", "run sticky", 32'(adapter_run), 32'd1);

        // random mix
        m_run = adapter_run;
        for (int k = 0; k < 300; k++) begin
            logic [2:0] op;
            logic [3:0] b;
            logic [7:0] d;
            op = 3'($urandom_range(0, 7));
            b  = ($urandom_range(0, 3) != 0) ? BOARD : 4'($urandom_range(0, 15));
            d  = 8'($urandom);
            issue(op, b, d, 4 + int'($urandom_range(0, 3)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule